// File: doc/BRIEF.md
# Interval Tick Timer with Sticky Interrupt Request

The block is a free-running binary counter that advances on a count-enable pulse. It has four interval taps, each a fixed counter bit, and a 2-bit select picks the active one. When an increment carries out of the selected tap bit, a sticky request flag is set. The flag is set whether or not interrupts are enabled. The interrupt line is the flag gated by an enable bit, and it is combinational, so a flag that is already pending reaches the line as soon as the enable is written to 1.

Software reaches the block through one 5-bit control register: a write port and a read port that are always valid. Each write updates every field at once, so a single access can enable the interrupt and discard a stale flag. No data streams in or out, so there is no valid/ready handshake. All pins are plain control and status.

Register layout:

| Bit(s) | Field | Behaviour |
|---|---|---|
| 0 | counter-clear | Active low; always reads 1 |
| 2:1 | interval select | Chooses the tap |
| 3 | interrupt enable | Gates the flag onto the interrupt line |
| 4 | request flag | Write 0 to clear; write 1 has no effect |

Top module: `itt_top`

## Requirements
- R1: With `tick` high, `count` increases by one on the next clock edge and wraps from all ones to zero. With `tick` low and no clear, `count` holds.
- R2: Select value n (0..3) picks tap TAPS[n]. An increment with `tick` high while `count` bits TAPS[n]..0 are all ones sets the flag (`rd_data[4]`) on that same edge.
- R3: The flag is set on a tap overflow even while the enable (`rd_data[3]`) is 0, and `irq` then stays low.
- R4: `irq` is high exactly when the flag and the enable are both 1. Writing enable 0→1 while the flag is pending raises `irq` right after that write edge, without waiting for a new overflow.
- R5: Writing 0 to bit 4 clears the flag. Writing 1 to bit 4 leaves the flag unchanged.
- R6: A write of 0 to the flag in the same cycle as a tap overflow leaves the flag at 0.
- R7: A write with bit 0 at 0 sets `count` to 0 on that edge, and an overflow in the same cycle does not set the flag. Bit 0 always reads as 1.
- R8: One write with enable 1 and flag 0 leaves the flag 0 and `irq` low after a pending flag.
- R9: After reset, `count` is 0, `irq` is 0 and `rd_data` is 5'b00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable pulse |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Write value (layout as above) |
| rd_data | output | 5 | Current control register value |
| count | output | CNT_W | Counter value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W = 6 and taps 1, 2, 3 and 5. The widest tap is then the top counter bit, so full wraps and carries out of every tap take tens of cycles rather than millions. The bench sweeps every select value with the enable both low and high, under an irregular `tick` pattern with occasional flag clears. A cycle-level arithmetic model is compared on every edge. Directed cases line a clear, a flag write or an enable write up with the exact overflow cycle.

// File: rtl/itt_pkg.sv
package itt_pkg;
  localparam int SEL_W  = 2;
  localparam int N_TAPS = 1 << SEL_W;
  localparam int CTRL_W = 5;

  typedef struct packed {
    logic             flag;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             clr_n;
  } ctrl_t;
endpackage

// File: rtl/itt_counter.sv
module itt_counter
  import itt_pkg::*;
#(
  parameter int          CNT_W        = 22,
  parameter int unsigned TAPS [N_TAPS] = '{12, 14, 17, 21}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_clr,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [N_TAPS-1:0] carry;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assign carry[i] = &cnt[TAPS[i]:0];
  end

  assign ovf = tick & carry[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_clr) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clr) |=> cnt == $past(cnt) + 1'b1);
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_clr) |=> $stable(cnt));
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt == '0);
endmodule

// File: rtl/itt_flag.sv
module itt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic cnt_clr,
  input  logic sw_clr,
  input  logic en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (sw_clr)           flag <= 1'b0;
    else if (ovf && !cnt_clr)  flag <= 1'b1;
  end

  assign irq = flag & en;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cnt_clr && !sw_clr) |=> flag);
  p_sw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !flag);
  p_clr_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && !flag) |=> !flag);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sw_clr) |=> flag);
endmodule

// File: rtl/itt_ctrl.sv
module itt_ctrl
  import itt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              flag,
  output logic              cnt_clr,
  output logic              sw_clr,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic [CTRL_W-1:0] rd_data
);
  ctrl_t wr, rd;

  assign wr      = ctrl_t'(wr_data);
  assign cnt_clr = wr_en & ~wr.clr_n;
  assign sw_clr  = wr_en & ~wr.flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      sel <= '0;
    end else if (wr_en) begin
      en  <= wr.en;
      sel <= wr.sel;
    end
  end

  always_comb begin
    rd       = '0;
    rd.flag  = flag;
    rd.en    = en;
    rd.sel   = sel;
    rd.clr_n = 1'b1;
  end
  assign rd_data = rd;

  p_fields_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en == $past(wr.en)) && (sel == $past(wr.sel)));
endmodule

// File: rtl/itt_top.sv
module itt_top
  import itt_pkg::*;
#(
  parameter int          CNT_W        = 22,
  parameter int unsigned TAPS [N_TAPS] = '{12, 14, 17, 21}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              irq
);
  logic             cnt_clr, sw_clr, en, flag, ovf;
  logic [SEL_W-1:0] sel;

  itt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flag(flag),
    .cnt_clr(cnt_clr), .sw_clr(sw_clr), .en(en), .sel(sel), .rd_data(rd_data)
  );

  itt_counter #(.CNT_W(CNT_W), .TAPS(TAPS)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_clr(cnt_clr), .sel(sel),
    .cnt(count), .ovf(ovf)
  );

  itt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .cnt_clr(cnt_clr), .sw_clr(sw_clr),
    .en(en), .flag(flag), .irq(irq)
  );

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[4] && rd_data[3]));
  p_irq_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && rd_data[3]) |-> irq);
  p_clr_reads_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0]);
endmodule

// File: tb/test_itt_top.sv
module test_itt_top;
  localparam int CNT_W = 6;
  localparam int unsigned TP [4] = '{1, 2, 3, 5};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             wr_en = 1'b0;
  logic [4:0]       wr_data = 5'b00001;
  logic [4:0]       rd_data;
  logic [CNT_W-1:0] count;
  logic             irq;

  int checks = 0;
  int fails  = 0;

  logic [CNT_W-1:0] m_cnt = '0;
  logic             m_flag = 1'b0, m_en = 1'b0;
  logic [1:0]       m_sel = '0;

  always #5 clk = ~clk;

  itt_top #(.CNT_W(CNT_W), .TAPS(TP)) i_itt_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .count(count), .irq(irq)
  );

  function automatic logic [4:0] cw(input logic flag, input logic en,
                                    input logic [1:0] sel, input logic clr_n);
    return {flag, en, sel, clr_n};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, update the model, compare after the edge.
  task automatic step(input logic t, input logic w, input logic [4:0] d, input string tag);
    logic [CNT_W-1:0] mask, n_cnt;
    logic clr, swc, ov, n_flag;
    @(negedge clk);
    tick = t; wr_en = w; wr_data = d;
    mask   = CNT_W'((64'd1 << (TP[m_sel] + 1)) - 1);
    clr    = w & ~d[0];
    swc    = w & ~d[4];
    ov     = t && ((m_cnt & mask) == mask);
    n_cnt  = clr ? '0 : (t ? m_cnt + 1'b1 : m_cnt);
    n_flag = swc ? 1'b0 : ((ov && !clr) ? 1'b1 : m_flag);
    m_cnt  = n_cnt;
    m_flag = n_flag;
    if (w) begin m_en = d[3]; m_sel = d[2:1]; end
    @(posedge clk); #1;
    chk(count == m_cnt, {tag, " count"}, int'(count), int'(m_cnt));
    chk(rd_data == {m_flag, m_en, m_sel, 1'b1}, {tag, " rd_data"}, int'(rd_data),
        int'({m_flag, m_en, m_sel, 1'b1}));
    chk(irq == (m_flag & m_en), {tag, " irq"}, int'(irq), int'(m_flag & m_en));
    tick = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(count == 0, "R9 count", int'(count), 0);
    chk(rd_data == 5'b00001, "R9 rd_data", int'(rd_data), 1);
    chk(irq == 1'b0, "R9 irq", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R4: sweep every select and enable with an irregular tick pattern
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 2; e++) begin
        step(1'b0, 1'b1, cw(1'b0, e[0], s[1:0], 1'b0), "R2 setup");
        for (int c = 0; c < 200; c++) begin
          if (c % 53 == 52) step(1'b1, 1'b1, cw(1'b0, e[0], s[1:0], 1'b1), "R5 sweep");
          else              step((c % 3) != 2, 1'b0, 5'b00001, "R1 R2 sweep");
        end
      end
    end

    // R3: overflow with enable low sets flag, irq stays low (tap 1: 4 ticks)
    step(1'b0, 1'b1, cw(1'b0, 1'b0, 2'd0, 1'b0), "R3 setup");
    for (int c = 0; c < 4; c++) step(1'b1, 1'b0, 5'b00001, "R3 run");
    chk(rd_data[4] == 1'b1, "R3 flag", int'(rd_data[4]), 1);
    chk(irq == 1'b0, "R3 irq", int'(irq), 0);

    // R4: enable 0->1 with pending flag raises irq at once
    step(1'b0, 1'b1, cw(1'b1, 1'b1, 2'd0, 1'b1), "R4 enable");
    chk(irq == 1'b1, "R4 irq", int'(irq), 1);

    // R8: enable and clear flag in one write after a pending flag
    step(1'b0, 1'b1, cw(1'b1, 1'b0, 2'd0, 1'b1), "R8 disable");
    chk(rd_data[4] == 1'b1, "R8 flag kept", int'(rd_data[4]), 1);
    step(1'b0, 1'b1, cw(1'b0, 1'b1, 2'd0, 1'b1), "R8 combined");
    chk(irq == 1'b0, "R8 irq", int'(irq), 0);
    chk(rd_data[4] == 1'b0, "R8 flag", int'(rd_data[4]), 0);

    // R5: writing 1 to the flag has no effect
    step(1'b0, 1'b1, cw(1'b1, 1'b1, 2'd0, 1'b1), "R5 write one");
    chk(rd_data[4] == 1'b0, "R5 flag", int'(rd_data[4]), 0);

    // R6: flag clear in the overflow cycle wins
    step(1'b0, 1'b1, cw(1'b0, 1'b1, 2'd0, 1'b0), "R6 setup");
    for (int c = 0; c < 3; c++) step(1'b1, 1'b0, 5'b00001, "R6 run");
    step(1'b1, 1'b1, cw(1'b0, 1'b1, 2'd0, 1'b1), "R6 collide");
    chk(rd_data[4] == 1'b0, "R6 flag", int'(rd_data[4]), 0);
    chk(count == 6'd4, "R6 count", int'(count), 4);

    // R7: counter clear in the overflow cycle suppresses the flag
    step(1'b0, 1'b1, cw(1'b0, 1'b1, 2'd0, 1'b0), "R7 setup");
    for (int c = 0; c < 3; c++) step(1'b1, 1'b0, 5'b00001, "R7 run");
    step(1'b1, 1'b1, cw(1'b1, 1'b1, 2'd0, 1'b0), "R7 collide");
    chk(count == 0, "R7 count", int'(count), 0);
    chk(rd_data[4] == 1'b0, "R7 flag", int'(rd_data[4]), 0);
    chk(rd_data[0] == 1'b1, "R7 reads one", int'(rd_data[0]), 1);
    chk(irq == 1'b0, "R7 irq", int'(irq), 0);

    // R1: full wrap from all ones to zero
    step(1'b0, 1'b1, cw(1'b0, 1'b0, 2'd3, 1'b0), "R1 setup");
    for (int c = 0; c < 64; c++) step(1'b1, 1'b0, 5'b00001, "R1 wrap");
    chk(count == 0, "R1 wrapped", int'(count), 0);
    chk(rd_data[4] == 1'b1, "R2 top tap", int'(rd_data[4]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule